// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer

This block is a small fully associative translation buffer for a device-side memory management unit. Every entry holds a tag word and a data word. The tag word carries a virtual tag, a 2-bit page-size code, a valid flag and a preserve flag. The data word carries the physical page address and three access attributes: byte order, element size and a mixed-attribute flag. Each entry compares the 32-bit lookup address under a mask that depends on that entry's own page size. Entries of 16 MB, 1 MB, 64 KB and 4 KB can therefore sit side by side in the table.

A lookup is answered one clock later, with one of three outcomes:
- a hit, which returns the translated address and the attributes;
- a miss;
- a multi-hit fault, raised when several valid entries claim the same address.

Misses and multi-hits set sticky status bits. Each status bit drives the interrupt output only when its enable bit is set.

Software-style writes go through a single port that takes an operation code. The operations stage tag and data words, load them into the entry the victim pointer selects, set the lock base and the victim pointer, flush entries, clear status bits and set the interrupt enables. Entries below the lock base are never replaced.

Top module: `pgtlb`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_multi`, `irq_status`, `irq`, `lock_base` and `victim` are all 0, and every entry is invalid.
- R2: Tag word layout: VA tag in bits 31:12, preserve flag in bit 3, valid flag in bit 2, size code in bits 1:0. The size code selects the compare mask: 0 gives 0xFFF00000 (1 MB), 1 gives 0xFFFF0000 (64 KB), 2 gives 0xFFFFF000 (4 KB) and 3 gives 0xFF000000 (16 MB). An entry matches when it is valid and the lookup address equals the tag under that mask.
- R3: On a hit, `rsp_pa` is made of two parts: the data word's physical address under the entry's mask, and the lookup address under the inverse mask. Data word layout: physical address in bits 31:12, big-endian flag in bit 9, element size in bits 8:7 (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = none), mixed flag in bit 6. These fields appear on `rsp_big`, `rsp_elsz` and `rsp_mixed`.
- R4: A lookup that matches no entry gives `rsp_miss` and sets `irq_status` bit 0.
- R5: A lookup that matches two or more entries gives `rsp_multi` with `rsp_hit` low and sets `irq_status` bit 4.
- R6: Write operations use `wr_op` codes: 0 stages the tag word, 1 stages the data word, and 2 loads the staged pair into entry `victim`. After a load, `victim` advances by one. From the last entry it wraps to `lock_base`.
- R7: Operation 3 sets `lock_base` from `wr_data` bits IW-1:0 and `victim` from `wr_data` bits 16+IW-1:16. A victim value below the base is raised to the base, so entries below `lock_base` are never loaded.
- R8: Operation 4 (global flush) invalidates every entry whose preserve flag is 0. Entries with the preserve flag set stay valid.
- R9: Operation 5 invalidates every entry that `wr_data`, taken as a virtual address, matches under that entry's mask. Other entries stay valid.
- R10: `irq_status` bits stay set until operation 6 writes a 1 to them. Operation 7 loads the enables from `wr_data` bits 4:0. `irq` is high exactly when some status bit and its enable bit are both set.
- R11: `rsp_valid` follows `lk_valid` by one cycle. While `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_multi` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| wr_en | input | 1 | Write operation strobe |
| wr_op | input | 3 | Operation code |
| wr_data | input | 32 | Operation operand |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Single match |
| rsp_miss | output | 1 | No match |
| rsp_multi | output | 1 | Multiple matches |
| rsp_pa | output | 32 | Translated address (0 unless hit) |
| rsp_big | output | 1 | Big-endian attribute |
| rsp_elsz | output | 2 | Element size attribute |
| rsp_mixed | output | 1 | Mixed attribute |
| irq_status | output | 5 | Sticky status (bit 0 miss, bit 4 multi-hit) |
| irq | output | 1 | Interrupt |
| lock_base | output | IW | Lock base |
| victim | output | IW | Next replacement index |

## Verification
The bench probes addresses one byte inside and one byte outside pages of each size. A wrong mask would show up as an off-by-one-page hit or miss. It nests a 4 KB page inside a 1 MB page to provoke multi-hits: a design that lets the first match win would report a clean hit with the wrong address. It walks the victim pointer past the last entry with a nonzero lock base. A wrap to zero would overwrite locked entries, which later lookups expose as misses. It flushes tables that mix preserved and unpreserved entries. It also clears status bits while a new miss arrives in the same window, so a clear that is not write-one-to-clear shows up as a lost or stuck status bit.

// File: rtl/pgtlb.sv
module pgtlb #(
  parameter int ENTRIES = 8,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [31:0]   lk_va,
  input  logic          wr_en,
  input  logic [2:0]    wr_op,
  input  logic [31:0]   wr_data,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic          rsp_miss,
  output logic          rsp_multi,
  output logic [31:0]   rsp_pa,
  output logic          rsp_big,
  output logic [1:0]    rsp_elsz,
  output logic          rsp_mixed,
  output logic [4:0]    irq_status,
  output logic          irq,
  output logic [IW-1:0] lock_base,
  output logic [IW-1:0] victim
);
  localparam logic [2:0] OP_TAG = 3'd0, OP_DATA = 3'd1, OP_LOAD = 3'd2, OP_LOCK = 3'd3,
                         OP_GFL = 3'd4, OP_VFL = 3'd5, OP_CLR = 3'd6, OP_IEN = 3'd7;

  function automatic logic [31:0] size_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'hFFF0_0000;
      2'd1:    return 32'hFFFF_0000;
      2'd2:    return 32'hFFFF_F000;
      default: return 32'hFF00_0000;
    endcase
  endfunction

  logic [31:0] tag_q  [ENTRIES];
  logic [31:0] data_q [ENTRIES];
  logic [31:0] stage_tag, stage_data;
  logic [4:0]  irq_en;
  logic [ENTRIES-1:0] lk_hit, fl_hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_hit[g] = tag_q[g][2] && (((tag_q[g] ^ lk_va)   & size_mask(tag_q[g][1:0])) == 32'd0);
    assign fl_hit[g] = tag_q[g][2] && (((tag_q[g] ^ wr_data) & size_mask(tag_q[g][1:0])) == 32'd0);
  end

  logic [IW:0]  hit_cnt;
  logic [31:0]  sel_pa, sel_data;
  always_comb begin
    hit_cnt  = '0;
    sel_pa   = '0;
    sel_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit[i]) begin
        hit_cnt  = hit_cnt + (IW+1)'(1);
        sel_pa   = sel_pa | (data_q[i] & size_mask(tag_q[i][1:0]))
                          | (lk_va & ~size_mask(tag_q[i][1:0]));
        sel_data = sel_data | data_q[i];
      end
    end
  end

  wire is_hit   = lk_valid && (hit_cnt == (IW+1)'(1));
  wire is_miss  = lk_valid && (hit_cnt == '0);
  wire is_multi = lk_valid && (hit_cnt > (IW+1)'(1));
  wire do_op    = wr_en;
  wire [IW-1:0] new_base = wr_data[IW-1:0];
  wire [IW-1:0] new_vict = wr_data[16 +: IW];
  wire [IW-1:0] next_vict = (victim == IW'(ENTRIES-1)) ? lock_base : victim + IW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
      stage_tag  <= '0;
      stage_data <= '0;
      lock_base  <= '0;
      victim     <= '0;
    end else if (do_op) begin
      case (wr_op)
        OP_TAG:  stage_tag  <= wr_data;
        OP_DATA: stage_data <= wr_data;
        OP_LOAD: begin
          tag_q[victim]  <= stage_tag;
          data_q[victim] <= stage_data;
          victim         <= next_vict;
        end
        OP_LOCK: begin
          lock_base <= new_base;
          victim    <= (new_vict < new_base) ? new_base : new_vict;
        end
        OP_GFL:
          for (int i = 0; i < ENTRIES; i++)
            if (!tag_q[i][3]) tag_q[i][2] <= 1'b0;
        OP_VFL:
          for (int i = 0; i < ENTRIES; i++)
            if (fl_hit[i]) tag_q[i][2] <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_status <= '0;
      irq_en     <= '0;
    end else begin
      irq_status <= ((do_op && wr_op == OP_CLR) ? (irq_status & ~wr_data[4:0]) : irq_status)
                    | {is_multi, 3'b000, is_miss};
      if (do_op && wr_op == OP_IEN) irq_en <= wr_data[4:0];
    end
  end

  assign irq = |(irq_status & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_pa    <= '0;
      rsp_big   <= 1'b0;
      rsp_elsz  <= '0;
      rsp_mixed <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= is_hit;
      rsp_miss  <= is_miss;
      rsp_multi <= is_multi;
      rsp_pa    <= is_hit ? sel_pa : 32'd0;
      rsp_big   <= is_hit & sel_data[9];
      rsp_elsz  <= is_hit ? sel_data[8:7] : 2'd0;
      rsp_mixed <= is_hit & sel_data[6];
    end
  end
endmodule

// File: rtl/pgtlb_chk.sv
module pgtlb_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          wr_en,
  input logic [2:0]    wr_op,
  input logic [31:0]   wr_data,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_miss,
  input logic          rsp_multi,
  input logic [4:0]    irq_status,
  input logic [IW-1:0] lock_base,
  input logic [IW-1:0] victim
);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_multi}) == 1));
  a_r4_miss_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> irq_status[0]);
  a_r5_multi_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> (irq_status[4] && !rsp_hit));
  a_r10_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[0] && !(wr_en && wr_op == 3'd6 && wr_data[0])) |=> irq_status[0]);
  a_r7_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    victim >= lock_base);
endmodule

bind pgtlb pgtlb_chk #(.IW(IW)) chk_i (.*);

// File: tb/pgtlb_tb_top.sv
module pgtlb_tb_top;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, wr_en = 0;
  logic [31:0] lk_va = 0, wr_data = 0;
  logic [2:0] wr_op = 0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_multi, rsp_big, rsp_mixed, irq;
  logic [31:0] rsp_pa;
  logic [1:0] rsp_elsz;
  logic [4:0] irq_status;
  logic [2:0] lock_base, victim;

  always #5 clk = ~clk;

  pgtlb #(.ENTRIES(N)) dut_i (.*);

  int tests = 0, fails = 0;
  logic [31:0] m_tag [N];
  logic [31:0] m_data [N];
  logic [31:0] m_st, m_sd;
  logic [2:0] m_base, m_vict;
  logic [4:0] m_stat, m_en;

  function automatic logic [31:0] msk(input logic [1:0] c);
    return c == 2'd0 ? 32'hFFF00000 : c == 2'd1 ? 32'hFFFF0000 :
           c == 2'd2 ? 32'hFFFFF000 : 32'hFF000000;
  endfunction
  function automatic bit mt(input logic [31:0] t, input logic [31:0] va);
    return t[2] && ((t & msk(t[1:0])) == (va & msk(t[1:0])));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] op, input logic [31:0] d, input string req);
    @(negedge clk); wr_en = 1; wr_op = op; wr_data = d;
    @(negedge clk); wr_en = 0;
    case (op)
      3'd0: m_st = d;
      3'd1: m_sd = d;
      3'd2: begin
        m_tag[m_vict] = m_st; m_data[m_vict] = m_sd;
        m_vict = (m_vict == 3'(N-1)) ? m_base : m_vict + 3'd1;
      end
      3'd3: begin m_base = d[2:0]; m_vict = (d[18:16] < d[2:0]) ? d[2:0] : d[18:16]; end
      3'd4: for (int i = 0; i < N; i++) if (!m_tag[i][3]) m_tag[i][2] = 1'b0;
      3'd5: begin
        logic [31:0] snap [N];
        for (int i = 0; i < N; i++) snap[i] = m_tag[i];
        for (int i = 0; i < N; i++) if (mt(snap[i], d)) m_tag[i][2] = 1'b0;
      end
      3'd6: m_stat = m_stat & ~d[4:0];
      default: m_en = d[4:0];
    endcase
    chk(lock_base == m_base, req, "lock_base R7", 32'(lock_base), 32'(m_base));
    chk(victim == m_vict, req, "victim R6", 32'(victim), 32'(m_vict));
    chk(irq_status == m_stat && irq == |(m_stat & m_en), req, "status R10",
        {irq, 26'd0, irq_status}, {|(m_stat & m_en), 26'd0, m_stat});
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] d, input string req);
    wr(3'd0, t, req); wr(3'd1, d, req); wr(3'd2, 32'd0, req);
  endtask

  task automatic look(input logic [31:0] va, input string req);
    int cnt = 0; logic [31:0] epa = 0, ed = 0;
    for (int i = 0; i < N; i++)
      if (mt(m_tag[i], va)) begin
        cnt++;
        epa = (m_data[i] & msk(m_tag[i][1:0])) | (va & ~msk(m_tag[i][1:0]));
        ed = m_data[i];
      end
    @(negedge clk); lk_valid = 1; lk_va = va;
    @(negedge clk); lk_valid = 0;
    if (cnt == 0) m_stat[0] = 1'b1;
    if (cnt > 1) m_stat[4] = 1'b1;
    chk(rsp_valid && rsp_hit == (cnt == 1) && rsp_miss == (cnt == 0) && rsp_multi == (cnt > 1),
        req, "outcome R11", {28'd0, rsp_valid, rsp_hit, rsp_miss, rsp_multi}, 32'(cnt));
    if (cnt == 1) begin
      chk(rsp_pa == epa, req, "pa R3", rsp_pa, epa);
      chk({rsp_big, rsp_elsz, rsp_mixed} == ed[9:6], req, "attr R3",
          32'({rsp_big, rsp_elsz, rsp_mixed}), 32'(ed[9:6]));
    end
    chk(irq_status == m_stat && irq == |(m_stat & m_en), req, "status R4 R5 R10",
        {irq, 26'd0, irq_status}, {|(m_stat & m_en), 26'd0, m_stat});
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin m_tag[i] = 0; m_data[i] = 0; end
    m_st = 0; m_sd = 0; m_base = 0; m_vict = 0; m_stat = 0; m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({rsp_valid, rsp_hit, rsp_miss, rsp_multi, irq, irq_status, lock_base, victim} == '0,
        "R1", "reset state", {rsp_valid, rsp_hit, rsp_miss, rsp_multi, irq, irq_status}, 0);
    look(32'h0000_0000, "R1");

    // R2 R3: one entry per page size
    load(32'h1200_0007, 32'h8000_0280, "R6");
    load(32'h2340_0004, 32'h9010_0040, "R6");
    load(32'h3456_0005, 32'hA000_0300, "R6");
    load(32'h4567_8006, 32'hB123_4180, "R6");
    look(32'h12FF_FFFF, "R2"); look(32'h1300_0000, "R2");
    look(32'h234F_FFFF, "R2"); look(32'h2350_0000, "R2");
    look(32'h3456_ABCD, "R3"); look(32'h3457_0000, "R2");
    look(32'h4567_8FFF, "R3"); look(32'h4567_9000, "R4");

    // R5: 4KB nested in 1MB
    load(32'h2345_6006, 32'hC000_0000, "R5");
    look(32'h2345_6010, "R5"); look(32'h2345_7010, "R3");

    // R10
    wr(3'd7, 32'h0000_0011, "R10");
    wr(3'd6, 32'h0000_0001, "R10");
    look(32'hDEAD_0000, "R4");
    wr(3'd6, 32'h0000_0010, "R10");
    wr(3'd7, 32'h0000_0010, "R10");
    wr(3'd6, 32'h0000_001F, "R10");

    // R7 R6: lock and wrap
    wr(3'd3, 32'h0001_0002, "R7");
    load(32'h5500_000F, 32'h0100_0000, "R6");
    load(32'h5600_000F, 32'h0200_0000, "R6");
    load(32'h5700_0003, 32'h0300_0000, "R6");
    load(32'h5800_0003, 32'h0400_0000, "R6");
    look(32'h1234_5678, "R7");
    wr(3'd3, 32'h0002_0006, "R7");
    load(32'h5900_0007, 32'h0500_0000, "R6");
    load(32'h5A00_0007, 32'h0600_0000, "R6");
    load(32'h5B00_0007, 32'h0700_0000, "R6");

    // R8 R9
    look(32'h5600_1000, "R8");
    wr(3'd4, 32'd0, "R8");
    look(32'h5600_1000, "R8"); look(32'h5B00_0000, "R8"); look(32'h1234_0000, "R8");
    wr(3'd5, 32'h5600_0ABC, "R9");
    look(32'h5600_1000, "R9"); look(32'h5500_0000, "R9");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int r = $urandom_range(0, 9);
      logic [31:0] base = {8'h10 + 8'($urandom_range(0, 2)), 4'h0, 20'($urandom)};
      if (r < 3) begin
        load({base[31:12], 8'd0, 1'($urandom), 1'($urandom_range(0, 5) != 0), 2'($urandom)},
             {$urandom} & 32'hFFFF_F3C0, "R6");
      end else if (r < 8) begin
        int e = $urandom_range(0, N-1);
        look((r < 6) ? {m_tag[e][31:12], 12'($urandom)} : base, "R2");
      end else if (r == 8) begin
        case ($urandom_range(0, 4))
          0: wr(3'd3, {13'd0, 3'($urandom), 13'd0, 3'($urandom)}, "R7");
          1: wr(3'd4, 32'd0, "R8");
          2: wr(3'd5, base, "R9");
          3: wr(3'd6, 32'($urandom_range(0, 31)), "R10");
          default: wr(3'd7, 32'($urandom_range(0, 31)), "R10");
        endcase
      end else begin
        look(base, "R4");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule